// File: doc/BRIEF.md
# Asynchronous Static RAM Byte Port

This block lets synchronous on-chip logic read and write single bytes in an external asynchronous static RAM with a 19-bit word address and an 8-bit data bus. The requester raises `req_valid` with an address, a direction flag and, for stores, a data byte. It holds these until `req_ack` pulses. The block then runs one complete memory cycle on the active-low select, output-enable and write-strobe pins and reports completion. A load returns its byte on `rd_data`, with a one-cycle `rd_valid` strobe.

Every phase of a memory cycle lasts a whole number of clocks. The block derives each count from a clock-period parameter and the memory's nanosecond limits, rounding up, with at least one clock per phase. Stores keep output-enable high for their whole length. The block turns on its own data driver only after output-enable has been high for a turnaround count. It keeps the driver on for one clock after the write strobe rises, which covers the data hold time. The physical pad is outside the block. The bus is therefore split into `mem_dq_out`, `mem_dq_oe` and `mem_dq_in`.

Top module: `asram_port`

## Requirements
- R1: During reset and whenever no request is in progress, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high and `mem_dq_oe`, `req_ack` and `rd_valid` are low.
- R2: A load (`req_write`=0) holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC clocks, where RD_CYC is the larger of the rounded-up cycle-time and access-time counts. `rd_data` then holds the byte on `mem_dq_in` sampled on the last of those clocks.
- R3: `rd_valid` is a one-clock pulse that coincides with `req_ack` after a load, and it never rises for a store.
- R4: A store (`req_write`=1) never lowers `mem_oe_n`, and it holds `mem_we_n` low for exactly WP_CYC clocks. WP_CYC is the largest of the rounded-up strobe-width, address-to-end and data-to-end counts.
- R5: `mem_dq_oe` rises only after `mem_oe_n` has been high for TURN_CYC clocks. It stays high in the clock in which `mem_we_n` rises, and it falls one clock later, for WP_CYC+1 clocks of drive per store. `mem_dq_out` carries the stored byte throughout.
- R6: While `mem_ce_n` stays low, `mem_addr` does not change, and it equals the address taken with the request.
- R7: `req_ack` is a one-clock pulse, with `mem_ce_n` high in that clock. It arrives RD_CYC+1 rising edges after a load is accepted, or TURN_CYC+WP_CYC+2 edges after a store is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending; held until `req_ack` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to store |
| req_ack | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W | Byte returned by the last load |
| rd_valid | output | 1 | One-clock strobe for `rd_data` |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Enables the data pad driver |
| mem_dq_in | input | DATA_W | Data from the memory pad |

## Verification
The properties assume that reset is asserted from time zero. They also assume that the requester lowers `req_valid` before the clock after `req_ack`; otherwise the same request would be taken a second time. The stimulus drops `req_valid` on the falling edge where it first sees the acknowledge. It drives the other request fields only between operations. The bench's memory model drives `mem_dq_in` only while the pins encode a read, so a load captured outside its window returns zero rather than the stored byte.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WPULSE,
    ST_WHOLD,
    ST_DONE
  } seq_state_t;

  // whole clocks covering t_ps, never fewer than one
  function automatic int cycles_for(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_tick.sv
module asram_tick #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC   = 2,
  parameter int WP_CYC   = 2,
  parameter int TURN_CYC = 1,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ack,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe
);

  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  seq_state_t state_q, state_d;
  logic ce_q, oe_q, we_q, dqoe_q, ack_q;
  logic ce_d, oe_d, we_d, dqoe_d, ack_d;

  // next state and phase-counter control
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_TURN;
            tmr_val = TURN_LD;
          end else begin
            state_d = ST_RD;
            tmr_val = RD_LD;
          end
        end
      end
      ST_RD: begin
        if (tmr_expired) begin
          capture = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_TURN: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          tmr_val  = WP_LD;
          state_d  = ST_WPULSE;
        end
      end
      ST_WPULSE: begin
        if (tmr_expired) begin
          state_d = ST_WHOLD;
        end
      end
      ST_WHOLD: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // pin levels decoded from the next state, so the pins change glitch-free with the state register
  always_comb begin
    ce_d   = !((state_d == ST_RD) || (state_d == ST_TURN) ||
               (state_d == ST_WPULSE) || (state_d == ST_WHOLD));
    oe_d   = (state_d != ST_RD);
    we_d   = (state_d != ST_WPULSE);
    dqoe_d = (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
    ack_d  = (state_d == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_q    <= 1'b1;
      oe_q    <= 1'b1;
      we_q    <= 1'b1;
      dqoe_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_q    <= ce_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      dqoe_q  <= dqoe_d;
      ack_q   <= ack_d;
    end
  end

  assign ce_n  = ce_q;
  assign oe_n  = oe_q;
  assign we_n  = we_q;
  assign dq_oe = dqoe_q;
  assign ack   = ack_q;

  // R4
  wp_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WPULSE && !tmr_expired) |=> (state_q == ST_WPULSE));

  // R2
  capture_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!ce_n && !oe_n && we_n));

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  // request fields, enabled by accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // load capture, enabled by capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= mem_dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rd_data    = rdata_q;
  assign rd_valid   = rvalid_q;

endmodule

// File: rtl/asram_port.sv
module asram_port
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 8000,
  parameter int T_RC_PS   = 12000,
  parameter int T_AA_PS   = 12000,
  parameter int T_WP_PS   = 9000,
  parameter int T_AW_PS   = 9000,
  parameter int T_DS_PS   = 6000,
  parameter int T_TURN_PS = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC   = imax(cycles_for(T_RC_PS, CLK_PS), cycles_for(T_AA_PS, CLK_PS));
  localparam int WP_CYC   = imax(cycles_for(T_WP_PS, CLK_PS),
                                 imax(cycles_for(T_AW_PS, CLK_PS), cycles_for(T_DS_PS, CLK_PS)));
  localparam int TURN_CYC = cycles_for(T_TURN_PS, CLK_PS);
  localparam int MAX_CYC  = imax(RD_CYC, imax(WP_CYC, TURN_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             accept;
  logic             capture;

  asram_tick #(.W(CNT_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  asram_seq #(
    .RD_CYC   (RD_CYC),
    .WP_CYC   (WP_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .accept      (accept),
    .capture     (capture),
    .ack         (req_ack),
    .ce_n        (mem_ce_n),
    .oe_n        (mem_oe_n),
    .we_n        (mem_we_n),
    .dq_oe       (mem_dq_oe)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  // R4
  oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R5
  drv_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

  // R5
  drv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe ##1 !mem_dq_oe);

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R3
  rvalid_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> req_ack);

  // R7
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  // R7
  ack_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> mem_ce_n);

endmodule

// File: tb/asram_port_test.sv
`timescale 1ns/1ps
module asram_port_test;

  localparam int AW     = 6;
  localparam int DW     = 8;
  localparam int CLK_PS = 8000;
  localparam int NWORDS = 1 << AW;

  function automatic int up_cyc(input int t, input int p);
    int c;
    c = (t + p - 1) / p;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD   = mx(up_cyc(12000, CLK_PS), up_cyc(12000, CLK_PS));
  localparam int E_WP   = mx(up_cyc(9000, CLK_PS), mx(up_cyc(9000, CLK_PS), up_cyc(6000, CLK_PS)));
  localparam int E_TURN = up_cyc(5000, CLK_PS);

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ack;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          mem_ce_n, mem_oe_n, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_in;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] mem [NWORDS];

  asram_port #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory model: drives only while the pins encode a read
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem[mem_addr] : '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pin monitor and store commit, on falling edges
  logic          prev_we_n, prev_ce_n, prev_dq_oe, rose_seen;
  logic [AW-1:0] prev_addr;
  int            oe_run;
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
      prev_we_n <= 1'b1; prev_ce_n <= 1'b1; prev_dq_oe <= 1'b0;
      rose_seen <= 1'b0; prev_addr <= '0; oe_run <= 0;
    end else begin
      if (!mem_we_n || !mem_oe_n)
        chk(mem_oe_n || mem_we_n, "R4 oe and we low together", 1, 0);
      if (mem_dq_oe && !prev_dq_oe)
        chk(oe_run >= E_TURN, "R5 turnaround before drive", oe_run, E_TURN);
      if (mem_dq_oe)
        chk(mem_oe_n, "R5 drive with oe low", 0, 1);
      if (mem_we_n && !prev_we_n) begin
        chk(mem_dq_oe, "R5 driver held at we rise", mem_dq_oe, 1);
        if (!mem_ce_n) mem[mem_addr] <= mem_dq_out;
      end
      if (rose_seen)
        chk(!mem_dq_oe, "R5 driver off after hold", mem_dq_oe, 0);
      if (!mem_ce_n && !prev_ce_n)
        chk(mem_addr == prev_addr, "R6 address moved", mem_addr, prev_addr);
      rose_seen  <= mem_we_n && !prev_we_n;
      oe_run     <= mem_oe_n ? oe_run + 1 : 0;
      prev_we_n  <= mem_we_n;
      prev_ce_n  <= mem_ce_n;
      prev_dq_oe <= mem_dq_oe;
      prev_addr  <= mem_addr;
    end
  end

  function automatic logic [DW-1:0] pat0(input int a);
    return DW'((a * 37 + 11) & 255);
  endfunction
  function automatic logic [DW-1:0] pat1(input int a);
    return DW'((a * 91 + 200) & 255);
  endfunction

  task automatic do_op(input bit w, input int a, input logic [DW-1:0] d, input logic [DW-1:0] exp_rd);
    int lat = 0, rdc = 0, wec = 0, drc = 0;
    req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d;
    while (1) begin
      @(negedge clk);
      lat++;
      if (!mem_ce_n && !mem_oe_n) rdc++;
      if (!mem_we_n) wec++;
      if (mem_dq_oe) begin
        drc++;
        chk(mem_dq_out == d, "R5 driven byte", mem_dq_out, d);
        chk(mem_addr == AW'(a), "R6 store address", mem_addr, a);
      end
      if (req_ack || lat > 40) break;
    end
    chk(req_ack, "R7 ack missing", req_ack, 1);
    chk(mem_ce_n, "R7 deselect during ack", mem_ce_n, 1);
    chk(lat == (w ? E_TURN + E_WP + 2 : E_RD + 1), "R7 latency", lat,
        w ? E_TURN + E_WP + 2 : E_RD + 1);
    chk(rd_valid == !w, "R3 rd_valid with ack", rd_valid, !w);
    if (w) begin
      chk(wec == E_WP, "R4 strobe width", wec, E_WP);
      chk(rdc == 0, "R4 oe low in store", rdc, 0);
      chk(drc == E_WP + 1, "R5 drive length", drc, E_WP + 1);
    end else begin
      chk(rdc == E_RD, "R2 read window", rdc, E_RD);
      chk(rd_data == exp_rd, "R2 read data", rd_data, exp_rd);
      chk(wec == 0 && drc == 0, "R2 strobe in load", wec + drc, 0);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ack && !rd_valid, "R7 ack single pulse", req_ack, 0);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 idle pins",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'he);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 reset pins",
        {mem_ce_n, mem_oe_n, mem_we_n}, 3'h7);
    chk(!mem_dq_oe && !req_ack && !rd_valid, "R1 reset outputs",
        {mem_dq_oe, req_ack, rd_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_ce_n && !mem_dq_oe, "R1 idle without request", mem_ce_n, 1);

    for (int a = 0; a < NWORDS; a++) do_op(1'b1, a, pat0(a), '0);
    for (int a = 0; a < NWORDS; a++) do_op(1'b0, a, '0, pat0(a));
    for (int a = NWORDS - 1; a >= 0; a--)
      if (a % 2 == 1) do_op(1'b1, a, pat1(a), '0);
    for (int a = 0; a < NWORDS; a++)
      do_op(1'b0, a, '0, (a % 2 == 1) ? pat1(a) : pat0(a));
    for (int a = 0; a < NWORDS; a += 5) begin
      do_op(1'b1, a, ~pat0(a), '0);
      do_op(1'b0, a, '0, ~pat0(a));
      do_op(1'b0, NWORDS - 1 - a, '0, ((NWORDS - 1 - a) % 2 == 1) ? pat1(NWORDS - 1 - a)
            : (((NWORDS - 1 - a) % 5 == 0) ? ~pat0(NWORDS - 1 - a) : pat0(NWORDS - 1 - a)));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule